// File: doc/BRIEF.md
# Power-Fail DRAM Self-Refresh Sequencer

This block takes over the command and control pins of a DDR4 channel when an early power-off warning arrives. It then walks the DRAM through a fixed shutdown program. It idles the bus, closes all banks, places the devices in self-refresh and finally pulls the DRAM reset low. A non-volatile module can then save its contents without losing them.

The power-warning logic first raises the takeover select. This swaps the output mux from the normal controller to the sequencer. The warning logic then pulses the start strobe. The wait after each step comes from run-time cycle counts for refresh recovery, precharge and self-refresh entry. When the select is low, the normal controller's pins pass straight through.

Top module: `pf_sr_seq`

## Requirements
- R1: When `takeover_i` is low, `cs_n_o`, `cke_o`, `reset_n_o` and `cmd_o` equal the matching `nrm_*` inputs in the same cycle, whatever the sequencer is doing.
- R2: After reset, and while idle with `takeover_i` high, the outputs are: all CKE high, all chip selects high, `reset_n_o` high, `cmd_o` = 5'b11110, `busy_o` = 0 and `done_o` = 0. A `go_i` pulse taken while `takeover_i` is low does not start the sequence.
- R3: A `go_i` sampled high with `takeover_i` high while idle starts the sequence with no delay. On the next cycle `busy_o` is 1 and the first step's pins are driven.
- R4: Step 1 (deselect) drives CKE high, all chip selects high, `reset_n_o` high and `cmd_o` = 5'b11110. It lasts `t_rfc_i`+1 cycles.
- R5: Step 2 (precharge all) drives CKE high, both 2-bit chip-select groups at 00, `reset_n_o` high and `cmd_o` = 5'b10101. It lasts `t_rp_i`+1 cycles. `cmd_o` bits from MSB to LSB are {ACT_n, RAS_n, CAS_n, WE_n, A10}.
- R6: Step 3 (self-refresh entry) drives CKE low, all chip selects low, `reset_n_o` high and `cmd_o` = 5'b10010. It lasts `t_cksre_i`+1 cycles.
- R7: Step 4 drives CKE low, all chip selects high, `reset_n_o` low and `cmd_o` = 5'b11110. It sets `done_o` = 1 and `busy_o` = 0, and holds this state until `clear_i`.
- R8: A wait count of zero makes its step last exactly one cycle.
- R9: `go_i` has no effect while busy or done. `clear_i` sampled while done returns the block to idle on the next cycle. `clear_i` has no effect in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| takeover_i | input | 1 | Selects the sequencer as the pin source |
| go_i | input | 1 | Start strobe |
| clear_i | input | 1 | Returns a finished sequence to idle |
| t_rfc_i | input | 16 | Refresh-recovery wait in cycles |
| t_rp_i | input | 8 | Precharge wait in cycles |
| t_cksre_i | input | 8 | Self-refresh entry wait in cycles |
| nrm_cs_n_i | input | 4 | Normal controller chip selects |
| nrm_cke_i | input | 2 | Normal controller clock enables |
| nrm_reset_n_i | input | 1 | Normal controller DRAM reset |
| nrm_cmd_i | input | 5 | Normal controller command {ACT_n,RAS_n,CAS_n,WE_n,A10} |
| cs_n_o | output | 4 | Chip selects to DRAM |
| cke_o | output | 2 | Clock enables to DRAM |
| reset_n_o | output | 1 | DRAM reset |
| cmd_o | output | 5 | Command pins {ACT_n,RAS_n,CAS_n,WE_n,A10} |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Final step reached |

## Verification
The pin mux is combinational, so a change on the takeover select shows on the outputs in the same cycle. Every step and flag change is registered. A start or clear sampled at one edge is visible just after that edge, and each step then keeps its pins for its wait count plus one cycle. The bench drives inputs on the falling edge. It advances its own step model on each rising edge and compares every output a quarter period after that edge, so each result is checked in the exact cycle it is due.

// File: rtl/pf_sr_pkg.sv
package pf_sr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DES  = 3'd1,
    ST_PREA = 3'd2,
    ST_SRE  = 3'd3,
    ST_DONE = 3'd4
  } step_e;

  // {act_n, ras_n, cas_n, we_n, a10}
  typedef struct packed {
    logic act_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } cmd_t;

  localparam cmd_t CMD_DES  = 5'b11110;
  localparam cmd_t CMD_PREA = 5'b10101;
  localparam cmd_t CMD_SRE  = 5'b10010;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pf_sr_timer.sv
module pf_sr_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pf_sr_ctrl.sv
module pf_sr_ctrl
  import pf_sr_pkg::*;
#(
  parameter int RFC_W = 16,
  parameter int RP_W  = 8,
  parameter int SRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             takeover_i,
  input  logic             go_i,
  input  logic             clear_i,
  input  logic [RFC_W-1:0] t_rfc_i,
  input  logic [RP_W-1:0]  t_rp_i,
  input  logic [SRE_W-1:0] t_cksre_i,
  output step_e            step_o
);
  localparam int CNT_W = max3(RFC_W, RP_W, SRE_W);

  step_e            step_q, step_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             wait_over;

  pf_sr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (wait_over)
  );

  always_comb begin
    step_d   = step_q;
    load     = 1'b0;
    load_val = '0;
    unique case (step_q)
      ST_IDLE: if (takeover_i && go_i) begin
        step_d   = ST_DES;
        load     = 1'b1;
        load_val = CNT_W'(t_rfc_i);
      end
      ST_DES: if (wait_over) begin
        step_d   = ST_PREA;
        load     = 1'b1;
        load_val = CNT_W'(t_rp_i);
      end
      ST_PREA: if (wait_over) begin
        step_d   = ST_SRE;
        load     = 1'b1;
        load_val = CNT_W'(t_cksre_i);
      end
      ST_SRE:  if (wait_over) step_d = ST_DONE;
      ST_DONE: if (clear_i)   step_d = ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_IDLE;
    else         step_q <= step_d;
  end

  assign step_o = step_q;
endmodule

// File: rtl/pf_sr_drive.sv
module pf_sr_drive
  import pf_sr_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int NUM_CKE = 2
) (
  input  step_e              step_i,
  output logic [NUM_CS-1:0]  cs_n_o,
  output logic [NUM_CKE-1:0] cke_o,
  output logic               reset_n_o,
  output cmd_t               cmd_o
);
  localparam int GRP_W   = 2;
  localparam int NUM_GRP = NUM_CS / GRP_W;

  logic cs_active, cke_on;

  always_comb begin
    cs_active = 1'b0;
    cke_on    = 1'b1;
    reset_n_o = 1'b1;
    cmd_o     = CMD_DES;
    unique case (step_i)
      ST_PREA: begin cs_active = 1'b1; cmd_o = CMD_PREA; end
      ST_SRE:  begin cs_active = 1'b1; cke_on = 1'b0; cmd_o = CMD_SRE; end
      ST_DONE: begin cke_on = 1'b0; reset_n_o = 1'b0; end
      default: ;
    endcase
  end

  // chip selects driven per two-rank group
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_cs_grp
    assign cs_n_o[g*GRP_W +: GRP_W] = cs_active ? {GRP_W{1'b0}} : {GRP_W{1'b1}};
  end

  assign cke_o = {NUM_CKE{cke_on}};
endmodule

// File: rtl/pf_sr_mux.sv
module pf_sr_mux
  import pf_sr_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int NUM_CKE = 2
) (
  input  logic               sel_seq_i,
  input  logic [NUM_CS-1:0]  seq_cs_n_i,
  input  logic [NUM_CKE-1:0] seq_cke_i,
  input  logic               seq_reset_n_i,
  input  cmd_t               seq_cmd_i,
  input  logic [NUM_CS-1:0]  nrm_cs_n_i,
  input  logic [NUM_CKE-1:0] nrm_cke_i,
  input  logic               nrm_reset_n_i,
  input  cmd_t               nrm_cmd_i,
  output logic [NUM_CS-1:0]  cs_n_o,
  output logic [NUM_CKE-1:0] cke_o,
  output logic               reset_n_o,
  output cmd_t               cmd_o
);
  always_comb begin
    if (sel_seq_i) begin
      cs_n_o    = seq_cs_n_i;
      cke_o     = seq_cke_i;
      reset_n_o = seq_reset_n_i;
      cmd_o     = seq_cmd_i;
    end else begin
      cs_n_o    = nrm_cs_n_i;
      cke_o     = nrm_cke_i;
      reset_n_o = nrm_reset_n_i;
      cmd_o     = nrm_cmd_i;
    end
  end
endmodule

// File: rtl/pf_sr_seq.sv
module pf_sr_seq
  import pf_sr_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int NUM_CKE = 2,
  parameter int RFC_W   = 16,
  parameter int RP_W    = 8,
  parameter int SRE_W   = 8,
  parameter int CMD_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               takeover_i,
  input  logic               go_i,
  input  logic               clear_i,
  input  logic [RFC_W-1:0]   t_rfc_i,
  input  logic [RP_W-1:0]    t_rp_i,
  input  logic [SRE_W-1:0]   t_cksre_i,
  input  logic [NUM_CS-1:0]  nrm_cs_n_i,
  input  logic [NUM_CKE-1:0] nrm_cke_i,
  input  logic               nrm_reset_n_i,
  input  logic [CMD_W-1:0]   nrm_cmd_i,
  output logic [NUM_CS-1:0]  cs_n_o,
  output logic [NUM_CKE-1:0] cke_o,
  output logic               reset_n_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic               busy_o,
  output logic               done_o
);
  step_e              step;
  logic [NUM_CS-1:0]  seq_cs_n;
  logic [NUM_CKE-1:0] seq_cke;
  logic               seq_reset_n;
  cmd_t               seq_cmd;
  cmd_t               mux_cmd;

  pf_sr_ctrl #(.RFC_W(RFC_W), .RP_W(RP_W), .SRE_W(SRE_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .takeover_i (takeover_i),
    .go_i       (go_i),
    .clear_i    (clear_i),
    .t_rfc_i    (t_rfc_i),
    .t_rp_i     (t_rp_i),
    .t_cksre_i  (t_cksre_i),
    .step_o     (step)
  );

  pf_sr_drive #(.NUM_CS(NUM_CS), .NUM_CKE(NUM_CKE)) u_drive (
    .step_i    (step),
    .cs_n_o    (seq_cs_n),
    .cke_o     (seq_cke),
    .reset_n_o (seq_reset_n),
    .cmd_o     (seq_cmd)
  );

  pf_sr_mux #(.NUM_CS(NUM_CS), .NUM_CKE(NUM_CKE)) u_mux (
    .sel_seq_i     (takeover_i),
    .seq_cs_n_i    (seq_cs_n),
    .seq_cke_i     (seq_cke),
    .seq_reset_n_i (seq_reset_n),
    .seq_cmd_i     (seq_cmd),
    .nrm_cs_n_i    (nrm_cs_n_i),
    .nrm_cke_i     (nrm_cke_i),
    .nrm_reset_n_i (nrm_reset_n_i),
    .nrm_cmd_i     (cmd_t'(nrm_cmd_i)),
    .cs_n_o        (cs_n_o),
    .cke_o         (cke_o),
    .reset_n_o     (reset_n_o),
    .cmd_o         (mux_cmd)
  );

  assign cmd_o  = CMD_W'(mux_cmd);
  assign busy_o = (step == ST_DES) || (step == ST_PREA) || (step == ST_SRE);
  assign done_o = (step == ST_DONE);
endmodule

// File: rtl/pf_sr_seq_chk.sv
module pf_sr_seq_chk #(
  parameter int NUM_CS  = 4,
  parameter int NUM_CKE = 2,
  parameter int RFC_W   = 16,
  parameter int RP_W    = 8,
  parameter int SRE_W   = 8,
  parameter int CMD_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               takeover_i,
  input logic               go_i,
  input logic               clear_i,
  input logic [RFC_W-1:0]   t_rfc_i,
  input logic [RP_W-1:0]    t_rp_i,
  input logic [SRE_W-1:0]   t_cksre_i,
  input logic [NUM_CS-1:0]  nrm_cs_n_i,
  input logic [NUM_CKE-1:0] nrm_cke_i,
  input logic               nrm_reset_n_i,
  input logic [CMD_W-1:0]   nrm_cmd_i,
  input logic [NUM_CS-1:0]  cs_n_o,
  input logic [NUM_CKE-1:0] cke_o,
  input logic               reset_n_o,
  input logic [CMD_W-1:0]   cmd_o,
  input logic               busy_o,
  input logic               done_o
);
  localparam logic [CMD_W-1:0] PREA = CMD_W'(5'b10101);
  localparam logic [CMD_W-1:0] SRE  = CMD_W'(5'b10010);

  p_idle_no_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !takeover_i && go_i && !busy_o && !done_o |=> !busy_o);

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    takeover_i && go_i && !busy_o && !done_o |=> busy_o);

  p_sre_after_prea_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    takeover_i && $past(takeover_i) && cmd_o == SRE && $past(cmd_o) != SRE
    |-> $past(cmd_o) == PREA);

  p_reset_after_cke_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    takeover_i && $past(takeover_i) && $fell(reset_n_o) |-> $past(cke_o) == '0);

  p_done_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clear_i |=> done_o && !busy_o);

  p_busy_done_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && clear_i |=> !done_o && !busy_o);
endmodule

bind pf_sr_seq pf_sr_seq_chk #(
  .NUM_CS(NUM_CS), .NUM_CKE(NUM_CKE), .RFC_W(RFC_W),
  .RP_W(RP_W), .SRE_W(SRE_W), .CMD_W(CMD_W)
) u_chk (.*);

// File: tb/sim_pf_sr_seq.sv
module sim_pf_sr_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       takeover_i = 1'b0, go_i = 1'b0, clear_i = 1'b0;
  logic [15:0] t_rfc_i = '0;
  logic [7:0]  t_rp_i = '0, t_cksre_i = '0;
  logic [3:0]  nrm_cs_n_i = '0;
  logic [1:0]  nrm_cke_i = '0;
  logic        nrm_reset_n_i = 1'b0;
  logic [4:0]  nrm_cmd_i = '0;
  logic [3:0]  cs_n_o;
  logic [1:0]  cke_o;
  logic        reset_n_o;
  logic [4:0]  cmd_o;
  logic        busy_o, done_o;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  int m_step = 0;   // 0 idle 1 des 2 prea 3 sre 4 done
  int m_cnt = 0;
  int m_age = 0;    // cycles spent in current step
  bit m_ign = 0;
  bit m_zero = 0;

  pf_sr_seq u0 (.*);

  always #10 clk_i = ~clk_i;

  // random normal-controller traffic
  always @(negedge clk_i) begin
    nrm_cs_n_i    <= 4'($urandom);
    nrm_cke_i     <= 2'($urandom);
    nrm_reset_n_i <= 1'($urandom);
    nrm_cmd_i     <= 5'($urandom);
  end

  // reference model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_step = 0; m_cnt = 0; m_age = 0; m_ign = 0;
    end else begin
      int nxt;
      nxt = m_step;
      m_ign = (go_i && m_step != 0) || (clear_i && m_step != 4);
      case (m_step)
        0: if (takeover_i && go_i) begin nxt = 1; m_cnt = int'(t_rfc_i); end
        1: if (m_cnt == 0) begin nxt = 2; m_cnt = int'(t_rp_i); end else m_cnt--;
        2: if (m_cnt == 0) begin nxt = 3; m_cnt = int'(t_cksre_i); end else m_cnt--;
        3: if (m_cnt == 0) nxt = 4; else m_cnt--;
        4: if (clear_i) nxt = 0;
        default: nxt = 0;
      endcase
      m_age = (nxt == m_step) ? m_age + 1 : 0;
      m_step = nxt;
    end
  end

  always @(posedge clk_i) begin
    #5;
    compare();
  end

  task automatic compare();
    logic [3:0] e_cs; logic [1:0] e_cke; logic e_rst; logic [4:0] e_cmd;
    logic e_busy, e_done;
    string tag;
    e_cs = 4'hF; e_cke = 2'b11; e_rst = 1'b1; e_cmd = 5'b11110;
    case (m_step)
      1: tag = (m_age == 0) ? "R3" : "R4";
      2: begin e_cs = 4'h0; e_cmd = 5'b10101; tag = "R5"; end
      3: begin e_cs = 4'h0; e_cke = 2'b00; e_cmd = 5'b10010; tag = "R6"; end
      4: begin e_cke = 2'b00; e_rst = 1'b0; tag = "R7"; end
      default: tag = "R2";
    endcase
    if (m_zero && m_step >= 1 && m_step <= 3) tag = "R8";
    if (m_ign) tag = "R9";
    if (!takeover_i) begin
      e_cs = nrm_cs_n_i; e_cke = nrm_cke_i; e_rst = nrm_reset_n_i; e_cmd = nrm_cmd_i;
      if (!m_ign) tag = "R1";
    end
    e_busy = (m_step >= 1 && m_step <= 3);
    e_done = (m_step == 4);
    n_chk++;
    if ({cs_n_o, cke_o, reset_n_o, cmd_o, busy_o, done_o} !==
        {e_cs, e_cke, e_rst, e_cmd, e_busy, e_done}) begin
      n_fail++;
      $display("FAIL %s t=%0t act cs=%b cke=%b rst=%b cmd=%b busy=%b done=%b exp cs=%b cke=%b rst=%b cmd=%b busy=%b done=%b",
        tag, $time, cs_n_o, cke_o, reset_n_o, cmd_o, busy_o, done_o,
        e_cs, e_cke, e_rst, e_cmd, e_busy, e_done);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_go();
    @(negedge clk_i) go_i = 1'b1;
    @(negedge clk_i) go_i = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk_i) clear_i = 1'b1;
    @(negedge clk_i) clear_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && m_step != 4; i++) @(negedge clk_i);
  endtask

  // watchdog
  always @(posedge clk_i) begin
    n_cyc++;
    if (n_cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    // R1: pass-through while not taken over
    cyc(6);
    // R2: go without takeover is ignored
    pulse_go();
    cyc(3);
    // R2 idle pins under takeover
    @(negedge clk_i) takeover_i = 1'b1;
    cyc(3);
    // R3-R7 nominal run
    t_rfc_i = 16'd5; t_rp_i = 8'd3; t_cksre_i = 8'd2;
    pulse_go();
    cyc(2);
    pulse_go();           // R9 go while busy
    wait_done();
    cyc(4);
    pulse_go();           // R9 go while done
    cyc(3);
    pulse_clear();        // R9 clear in done
    cyc(3);
    pulse_clear();        // R9 clear while idle
    cyc(2);
    // R8 all waits zero
    t_rfc_i = '0; t_rp_i = '0; t_cksre_i = '0;
    m_zero = 1;
    pulse_go();
    wait_done();
    m_zero = 0;
    cyc(2);
    pulse_clear();
    cyc(2);
    // R1 takeover dropped mid-run, sequence keeps going
    t_rfc_i = 16'd300; t_rp_i = 8'd7; t_cksre_i = 8'd4;
    pulse_go();
    cyc(20);
    @(negedge clk_i) takeover_i = 1'b0;
    cyc(10);
    @(negedge clk_i) takeover_i = 1'b1;
    wait_done();
    cyc(5);
    // async reset out of done returns to R2 state
    @(negedge clk_i) rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule